// File: doc/BRIEF.md
# Non-throttling multichannel stream receiver

The receiver takes one AXI4-Stream input and routes every beat to one of `NCH` per-channel output streams, picked by the beat's TDEST value. It never pushes back on its source: the input ready is tied high, and a beat that cannot be delivered is thrown away. A busy or switched-off channel therefore cannot stall traffic bound for any other channel.

Each channel has a one-beat output register, an enable input, a saturating drop counter and its own interrupt line. The interrupt goes high when a complete packet has been handed to that channel's output. Delivery never produces a partial packet. Once a packet loses any beat, the rest of that packet on that channel is discarded up to and including its TLAST. A channel that is switched on in the middle of a packet waits for the next packet before it delivers anything.

Top module: `stream_rx_demux`

## Requirements
- R1: A beat with `s_valid` high and `s_dest` = c (c < NCH) that is accepted appears on channel c's output one cycle later, with its data and last flag, in arrival order.
- R2: `s_ready` is 1 in every cycle, including during reset.
- R3: A beat sent to a channel whose `ch_en` bit is 0 is discarded and increments that channel's drop counter.
- R4: Channel c accepts a beat when its output register is empty or is being drained in the same cycle (`m_valid` and `m_ready` both high). Otherwise the beat is discarded and counted.
- R5: After a beat of a packet is discarded, every later beat of that packet on that channel, up to and including the one with last set, is discarded and counted. The beat after that last beat starts a new packet.
- R6: If a packet's first beat arrives while the channel is disabled, the whole packet is discarded even if the channel is enabled before the packet ends.
- R7: A beat whose `s_dest` is NCH or above is discarded and changes no channel's output, counter or interrupt.
- R8: `irq[c]` is set by an accepted beat with last set, which is visible on the output in the same cycle. It is cleared by a one-cycle `irq_clr[c]` pulse. When both happen in the same cycle, the set takes priority.
- R9: While `m_valid[c]` is high and `m_ready[c]` is low, the channel's output data, last flag and valid stay unchanged.
- R10: Each drop counter is `CNTW` bits wide and saturates at all ones.
- R11: After reset every `m_valid`, `irq` and drop counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat valid |
| s_data | input | DW | Input beat data |
| s_dest | input | DESTW | Destination channel index |
| s_last | input | 1 | Last beat of a packet |
| s_ready | output | 1 | Input ready, always 1 |
| ch_en | input | NCH | Per-channel enable |
| irq_clr | input | NCH | Per-channel interrupt clear pulse |
| m_valid | output | NCH | Per-channel output valid |
| m_data | output | NCH*DW | Per-channel output data, channel c at bits [c*DW +: DW] |
| m_last | output | NCH | Per-channel output last flag |
| m_ready | input | NCH | Per-channel output ready |
| irq | output | NCH | Per-channel packet-complete interrupt |
| drop_cnt | output | NCH*CNTW | Per-channel discarded-beat count, channel c at bits [c*CNTW +: CNTW] |

## Verification
The hardest case to reach is a drop in the middle of a packet caused only by a full output register. It takes a beat that fills the register while `m_ready` is held low, then further beats of the same packet, interleaved with live traffic on other channels, so that the tail drop and the independence of the other channels can be seen together. The stimulus also covers enabling a channel partway through a packet, clearing an interrupt in the same cycle as a new packet end, and refilling a register in the same cycle it drains. The bench's scoreboard keeps a per-channel model of register occupancy and packet state driven by the same `m_ready` pattern. Any beat that reaches an output without being expected counts as a failure.

// File: rtl/stream_rx_demux.sv
module stream_rx_demux #(
  parameter int NCH   = 4,
  parameter int DW    = 32,
  parameter int DESTW = 3,
  parameter int CNTW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DW-1:0]     s_data,
  input  logic [DESTW-1:0]  s_dest,
  input  logic              s_last,
  output logic              s_ready,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH-1:0]    irq_clr,
  output logic [NCH-1:0]    m_valid,
  output logic [NCH*DW-1:0] m_data,
  output logic [NCH-1:0]    m_last,
  input  logic [NCH-1:0]    m_ready,
  output logic [NCH-1:0]    irq,
  output logic [NCH*CNTW-1:0] drop_cnt
);
  localparam logic [CNTW-1:0] CMAX = '1;

  assign s_ready = 1'b1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [DESTW-1:0] ID = DESTW'(c);
    logic hit, room, drop, take;
    logic vld, lst, inpkt, skip, irq_q;
    logic [DW-1:0]   dat;
    logic [CNTW-1:0] cnt;

    assign hit  = s_valid && (s_dest == ID);
    assign room = !vld || m_ready[c];
    assign drop = (inpkt && skip) || !(ch_en[c] && room);
    assign take = hit && !drop;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        inpkt <= 1'b0;
        skip  <= 1'b0;
        cnt   <= '0;
      end else if (hit) begin
        inpkt <= !s_last;
        skip  <= !s_last && drop;
        if (drop && cnt != CMAX) cnt <= cnt + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld <= 1'b0;
        lst <= 1'b0;
        dat <= '0;
      end else if (take) begin
        vld <= 1'b1;
        lst <= s_last;
        dat <= s_data;
      end else if (m_ready[c]) begin
        vld <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)              irq_q <= 1'b0;
      else if (take && s_last) irq_q <= 1'b1;
      else if (irq_clr[c])     irq_q <= 1'b0;
    end

    assign m_valid[c]             = vld;
    assign m_last[c]              = lst;
    assign m_data[c*DW +: DW]     = dat;
    assign irq[c]                 = irq_q;
    assign drop_cnt[c*CNTW +: CNTW] = cnt;
  end
endmodule

// File: rtl/stream_rx_demux_chk.sv
module stream_rx_demux_chk #(
  parameter int NCH   = 4,
  parameter int DW    = 32,
  parameter int DESTW = 3,
  parameter int CNTW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic [DW-1:0]     s_data,
  input logic [DESTW-1:0]  s_dest,
  input logic              s_last,
  input logic              s_ready,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    irq_clr,
  input logic [NCH-1:0]    m_valid,
  input logic [NCH*DW-1:0] m_data,
  input logic [NCH-1:0]    m_last,
  input logic [NCH-1:0]    m_ready,
  input logic [NCH-1:0]    irq,
  input logic [NCH*CNTW-1:0] drop_cnt
);
  localparam logic [CNTW-1:0] CMAX = '1;

  a_r2_never_throttle: assert property (@(posedge clk) s_ready);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    localparam logic [DESTW-1:0] ID = DESTW'(c);

    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid[c] && !m_ready[c] |=> m_valid[c] && $stable(m_data[c*DW +: DW]) && $stable(m_last[c]));

    a_r8_irq_with_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[c]) |-> m_valid[c] && m_last[c]);

    a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr[c] && !(s_valid && s_dest == ID) |=> !irq[c]);

    a_r3_disabled_no_out: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid && s_dest == ID && !ch_en[c] && !m_valid[c] |=> !m_valid[c]);

    a_r3_disabled_counts: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid && s_dest == ID && !ch_en[c] && drop_cnt[c*CNTW +: CNTW] != CMAX
      |=> drop_cnt[c*CNTW +: CNTW] == $past(drop_cnt[c*CNTW +: CNTW]) + 1'b1);

    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      drop_cnt[c*CNTW +: CNTW] == CMAX |=> drop_cnt[c*CNTW +: CNTW] == CMAX);
  end
endmodule

bind stream_rx_demux stream_rx_demux_chk #(.NCH(NCH), .DW(DW), .DESTW(DESTW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_dest(s_dest),
  .s_last(s_last), .s_ready(s_ready), .ch_en(ch_en), .irq_clr(irq_clr),
  .m_valid(m_valid), .m_data(m_data), .m_last(m_last), .m_ready(m_ready),
  .irq(irq), .drop_cnt(drop_cnt));

// File: tb/sim_stream_rx_demux.sv
module sim_stream_rx_demux;
  localparam int CLK   = 10;
  localparam int NCH   = 4;
  localparam int DW    = 16;
  localparam int DESTW = 3;
  localparam int CNTW  = 3;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_last = 0, s_ready;
  logic [DW-1:0] s_data = '0;
  logic [DESTW-1:0] s_dest = '0;
  logic [NCH-1:0] ch_en = '0, irq_clr = '0, m_ready = '0;
  logic [NCH-1:0] m_valid, m_last, irq;
  logic [NCH*DW-1:0] m_data;
  logic [NCH*CNTW-1:0] drop_cnt;

  always #(CLK/2) clk = ~clk;

  stream_rx_demux #(.NCH(NCH), .DW(DW), .DESTW(DESTW), .CNTW(CNTW)) u0 (.*);

  int tests = 0, fails = 0;
  logic [DW:0] q0[$], q1[$], q2[$], q3[$];
  bit occ[NCH], inpkt[NCH], skip[NCH], mirq[NCH];
  int mcnt[NCH];
  logic [NCH-1:0] en_r = '0, rdy_r = '1;

  task automatic push(int c, logic [DW:0] it);
    case (c)
      0: q0.push_back(it);
      1: q1.push_back(it);
      2: q2.push_back(it);
      default: q3.push_back(it);
    endcase
  endtask

  function automatic int qsize(int c);
    case (c)
      0: return q0.size();
      1: return q1.size();
      2: return q2.size();
      default: return q3.size();
    endcase
  endfunction

  // scoreboard monitor: every delivered beat must match the head of its channel queue (R1)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (m_valid[c] && m_ready[c]) begin
          logic [DW:0] got, exp;
          got = {m_last[c], m_data[c*DW +: DW]};
          tests++;
          if (qsize(c) == 0) begin
            fails++;
            $display("FAIL R1/R5/R7 ch%0d unexpected beat actual=%h expected=none", c, got);
          end else begin
            case (c)
              0: exp = q0.pop_front();
              1: exp = q1.pop_front();
              2: exp = q2.pop_front();
              default: exp = q3.pop_front();
            endcase
            if (got !== exp) begin
              fails++;
              $display("FAIL R1 ch%0d actual=%h expected=%h", c, got, exp);
            end
          end
        end
      end
    end
  end

  // one clock: optionally compare state, then drive inputs and advance the model
  task automatic cyc(bit v, int d, logic [DW-1:0] dat, bit l, logic [NCH-1:0] clr, bit chk, string tag);
    @(posedge clk); #1;
    if (chk) begin
      for (int c = 0; c < NCH; c++) begin
        tests += 2;
        if (irq[c] !== mirq[c]) begin
          fails++;
          $display("FAIL %s R8 irq[%0d] actual=%0b expected=%0b", tag, c, irq[c], mirq[c]);
        end
        if (drop_cnt[c*CNTW +: CNTW] !== CNTW'(mcnt[c])) begin
          fails++;
          $display("FAIL %s R3/R4/R5/R10 cnt[%0d] actual=%0d expected=%0d", tag, c,
                   drop_cnt[c*CNTW +: CNTW], mcnt[c]);
        end
      end
      tests++;
      if (s_ready !== 1'b1) begin
        fails++;
        $display("FAIL %s R2 s_ready actual=%b expected=1", tag, s_ready);
      end
    end
    s_valid = v; s_dest = DESTW'(d); s_data = dat; s_last = l;
    irq_clr = clr; ch_en = en_r; m_ready = rdy_r;
    for (int c = 0; c < NCH; c++) begin
      bit hit, room, drp, acc;
      hit  = v && d == c;
      room = !occ[c] || rdy_r[c];
      drp  = (inpkt[c] && skip[c]) || !(en_r[c] && room);
      acc  = hit && !drp;
      if (hit) begin
        if (drp && mcnt[c] < (1 << CNTW) - 1) mcnt[c]++;
        if (acc) push(c, {l, dat});
        skip[c]  = !l && drp;
        inpkt[c] = !l;
      end
      occ[c]  = acc ? 1'b1 : (rdy_r[c] ? 1'b0 : occ[c]);
      mirq[c] = (acc && l) ? 1'b1 : (clr[c] ? 1'b0 : mirq[c]);
    end
  endtask

  task automatic beat(int d, logic [DW-1:0] dat, bit l);
    cyc(1, d, dat, l, '0, 0, "");
  endtask

  task automatic idle_chk(string tag);
    cyc(0, 0, '0, 0, '0, 1, tag);
  endtask

  bit done = 0;
  initial begin
    #(CLK * 100000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state, R2 during reset
    tests += 4;
    if (m_valid !== '0) begin fails++; $display("FAIL R11 m_valid actual=%b expected=0", m_valid); end
    if (irq !== '0) begin fails++; $display("FAIL R11 irq actual=%b expected=0", irq); end
    if (drop_cnt !== '0) begin fails++; $display("FAIL R11 drop_cnt actual=%h expected=0", drop_cnt); end
    if (s_ready !== 1'b1) begin fails++; $display("FAIL R2 s_ready in reset actual=%b expected=1", s_ready); end
    rst_n = 1;

    // R1 interleaved packets on several channels
    en_r = 4'b1111; rdy_r = 4'b1111;
    beat(0, 16'h0010, 0); beat(1, 16'h0020, 0); beat(0, 16'h0011, 0);
    beat(1, 16'h0021, 1); beat(0, 16'h0012, 1); beat(3, 16'h0030, 1);
    idle_chk("R1");
    // R8 clear together with a new packet end on ch0: set wins
    cyc(1, 0, 16'h0013, 1, 4'b1011, 1, "R8a");
    idle_chk("R8b");
    cyc(0, 0, '0, 0, 4'b1111, 1, "R8c");
    idle_chk("R8d");

    // R3 disabled channel, then R10 saturation
    en_r = 4'b1101;
    beat(1, 16'h0100, 0); beat(0, 16'h0040, 0); beat(1, 16'h0101, 0);
    beat(1, 16'h0102, 1); beat(0, 16'h0041, 1);
    idle_chk("R3");
    for (int i = 0; i < 9; i++) beat(1, DW'(16'h0200 + i), 1);
    idle_chk("R10");

    // R4/R5/R9 stalled ch2, traffic on ch0 continues
    en_r = 4'b1111; rdy_r = 4'b1011;
    beat(2, 16'h0300, 0); beat(0, 16'h0050, 0); beat(2, 16'h0301, 0);
    beat(0, 16'h0051, 1); beat(2, 16'h0302, 0); beat(2, 16'h0303, 1);
    idle_chk("R5");
    rdy_r = 4'b1111;
    idle_chk("R9");
    beat(2, 16'h0310, 0); beat(2, 16'h0311, 1);
    idle_chk("R5b");
    // R4 refill in the same cycle the register drains
    rdy_r = 4'b1011;
    beat(2, 16'h0320, 1); idle_chk("R4a");
    rdy_r = 4'b1111;
    beat(2, 16'h0321, 0); beat(2, 16'h0322, 1);
    idle_chk("R4b");

    // R7 out-of-range destinations
    beat(5, 16'h0400, 0); beat(7, 16'h0401, 1); beat(4, 16'h0402, 1);
    idle_chk("R7");

    // R6 enable during a packet
    en_r = 4'b0111;
    beat(3, 16'h0500, 0);
    en_r = 4'b1111;
    beat(3, 16'h0501, 0); beat(3, 16'h0502, 1);
    beat(3, 16'h0510, 1);
    idle_chk("R6");
    cyc(0, 0, '0, 0, 4'b1111, 1, "R6b");
    repeat (3) idle_chk("end");

    for (int c = 0; c < NCH; c++) begin
      tests++;
      if (qsize(c) != 0) begin
        fails++;
        $display("FAIL R1 ch%0d undelivered beats actual=%0d expected=0", c, qsize(c));
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule